// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block keeps the event status and the interrupt enable mask of an SD/MMC host controller and drives a single active-low interrupt request. Single-cycle pulses from the command engine, the data path and card detection set sticky status bits. A few bits are plain views of live level inputs: card signal state, write protect and command busy. Because command busy is live, software can tell whether a write is still in progress when the data-end event arrives.

Software sees each 32-bit register as two 16-bit halfword locations on a simple register bus. To acknowledge an event, it writes the status register with a 0 in that event's bit and 1 everywhere else. To disable a source, it sets the matching mask bit. The interrupt line is asserted while any status bit is set and its mask bit is clear.

Top module: `sd_irq_status`

## Requirements
- R1: Sticky status bits sit at these positions: 0 command response end, 2 data end, 3 card removed, 4 card inserted, 16 command index error, 17 CRC fail, 18 stop bit error, 19 data timeout, 20 receive overflow, 21 transmit underrun, 22 command timeout, 24 receive ready, 25 transmit request, 29 illegal function, 31 illegal access. A 1 on the matching `evt` bit sets the bit. It stays set until software clears it. `evt` bits at other positions have no effect.
- R2: A status write clears each sticky bit in the written half where the data bit is 0, and leaves bits written as 1 unchanged. Status bits 15:0 are at byte address 0x1C and bits 31:16 are at 0x1E.
- R3: Status bit 5 reads `card_sig`, bit 7 reads `wr_prot` and bit 30 reads `cmd_busy`, with no delay. Writes do not change these bits. All other status bits read 0.
- R4: The mask register is read and written as bits 15:0 at 0x20 and bits 31:16 at 0x22. Writing a location replaces that half.
- R5: A halfword write changes only the half that was addressed. The other half of the same register and the other register keep their values.
- R6: `irq_n` is a register. One cycle after any status bit (sticky or level) is 1 while its mask bit is 0, it is 0. It returns to 1 in the cycle after the last such bit is cleared or masked.
- R7: If an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R8: Synchronous reset clears all sticky bits, loads the mask with 0x837F031D and drives `irq_n` to 1.
- R9: Reads of any other address return 0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for one halfword |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| evt | input | 32 | Event pulses, one per status bit position |
| card_sig | input | 1 | Live card signal state |
| wr_prot | input | 1 | Live write-protect level |
| cmd_busy | input | 1 | Live command busy level |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume `rst` is held for at least one clock before checking starts. They also assume `evt` and `wr_en` are sampled only at the rising edge, so a pulse lasts exactly one cycle. The random stimulus changes every input only at falling edges. It keeps events sparse by ANDing several random words, so clearing, masking and the event-versus-write collision all occur often. Addresses are drawn mostly from the four mapped locations and sometimes from unmapped ones, so the ignored-access case is also covered.

// File: rtl/sd_irq_status.sv
module sd_irq_status #(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h20,
  parameter logic [31:0] MASK_INIT = 32'h837F_031D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic [31:0]       evt,
  input  logic              card_sig,
  input  logic              wr_prot,
  input  logic              cmd_busy,
  output logic              irq_n
);
  localparam logic [31:0] STICKY = 32'hA37F_001D;
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(2);

  logic [31:0] stk_q, mask_q, lvl, stat_view, keep;
  logic        sel_sl, sel_sh, sel_ml, sel_mh;

  assign sel_sl = addr == STAT_OFS;
  assign sel_sh = addr == STAT_OFS + HI;
  assign sel_ml = addr == MASK_OFS;
  assign sel_mh = addr == MASK_OFS + HI;

  always_comb begin
    lvl = '0;
    lvl[5]  = card_sig;
    lvl[7]  = wr_prot;
    lvl[30] = cmd_busy;
  end

  assign stat_view = stk_q | lvl;
  assign keep = {(wr_en && sel_sh) ? wr_data : 16'hFFFF,
                 (wr_en && sel_sl) ? wr_data : 16'hFFFF};

  always_comb begin
    rd_data = '0;
    if (sel_sl) rd_data = stat_view[15:0];
    if (sel_sh) rd_data = stat_view[31:16];
    if (sel_ml) rd_data = mask_q[15:0];
    if (sel_mh) rd_data = mask_q[31:16];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_q  <= '0;
      mask_q <= MASK_INIT;
      irq_n  <= 1'b1;
    end else begin
      stk_q <= ((stk_q & keep) | evt) & STICKY;
      if (wr_en && sel_ml) mask_q[15:0]  <= wr_data;
      if (wr_en && sel_mh) mask_q[31:16] <= wr_data;
      irq_n <= ~|(stat_view & ~mask_q);
    end
  end
endmodule

module sd_irq_status_chk #(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h20,
  parameter logic [31:0] MASK_INIT = 32'h837F_031D
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       evt,
  input logic [31:0]       stk_q,
  input logic [31:0]       mask_q,
  input logic [31:0]       stat_view,
  input logic              irq_n
);
  localparam logic [31:0] STICKY = 32'hA37F_001D;
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(2);

  logic stat_wr, mask_wr;
  assign stat_wr = wr_en && (addr == STAT_OFS || addr == STAT_OFS + HI);
  assign mask_wr = wr_en && (addr == MASK_OFS || addr == MASK_OFS + HI);

  assert_bits_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stk_q & $past(stk_q)) == $past(stk_q)));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|(evt & STICKY)) |=> ((stk_q & $past(evt & STICKY)) == $past(evt & STICKY)));

  assert_mask_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask_q));

  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_n == !$past(|(stat_view & ~mask_q))));

  assert_reset_state_R8: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == MASK_INIT && stk_q == '0 && irq_n));
endmodule

bind sd_irq_status sd_irq_status_chk #(
  .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS), .MASK_INIT(MASK_INIT)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .evt(evt),
  .stk_q(stk_q), .mask_q(mask_q), .stat_view(stat_view), .irq_n(irq_n)
);

// File: tb/sim_sd_irq_status.sv
module sim_sd_irq_status;
  localparam logic [31:0] STICKY = 32'hA37F_001D;
  localparam logic [31:0] MINIT  = 32'h837F_031D;

  logic clk = 0, rst = 1, wr_en = 0, card_sig = 0, wr_prot = 0, cmd_busy = 0;
  logic [8:0] addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [31:0] evt = '0;
  logic irq_n;

  int total = 0, fails = 0;
  logic [31:0] m_stk = '0, m_mask = MINIT;
  logic m_irqn = 1;

  always #10 clk = ~clk;

  sd_irq_status u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt(evt), .card_sig(card_sig), .wr_prot(wr_prot),
    .cmd_busy(cmd_busy), .irq_n(irq_n));

  function automatic logic [31:0] lvl_bits();
    logic [31:0] l = '0;
    l[5] = card_sig; l[7] = wr_prot; l[30] = cmd_busy;
    return l;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [8:0] a);
    logic [31:0] s = m_stk | lvl_bits();
    case (a)
      9'h01C: return s[15:0];
      9'h01E: return s[31:16];
      9'h020: return m_mask[15:0];
      9'h022: return m_mask[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [8:0] a, input logic [15:0] d, input logic [31:0] e);
    logic [31:0] ns, nm;
    logic ni;
    wr_en = w; addr = a; wr_data = d; evt = e;
    ni = !(|((m_stk | lvl_bits()) & ~m_mask));
    ns = m_stk; nm = m_mask;
    if (w) begin
      if (a == 9'h01C) ns[15:0]  = ns[15:0] & d;
      if (a == 9'h01E) ns[31:16] = ns[31:16] & d;
      if (a == 9'h020) nm[15:0]  = d;
      if (a == 9'h022) nm[31:16] = d;
    end
    ns = (ns | e) & STICKY;
    @(posedge clk);
    m_stk = ns; m_mask = nm; m_irqn = ni;
    @(negedge clk);
    wr_en = 0; evt = '0;
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    addr = a; #1;
    chk(tag, {16'h0, rd_data}, {16'h0, exp_rd(a)});
  endtask

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5D1C));
    repeat (3) @(negedge clk);
    rst = 0;
    rd(9'h020, "R8 mask low after reset");
    rd(9'h022, "R8 mask high after reset");
    rd(9'h01C, "R8 status low after reset");
    chk("R8 irq_n after reset", {31'h0, irq_n}, 32'h1);

    step(0, 9'h0, 0, 32'hFFFF_FFFF);
    rd(9'h01C, "R1 all events low half");
    rd(9'h01E, "R1 all events high half");
    step(1, 9'h01C, 16'hFFFE, 32'h0);
    rd(9'h01C, "R2 clear bit0 only");
    step(1, 9'h01C, 16'hFFFB, 32'h0000_0004);
    rd(9'h01C, "R7 event beats clear");
    step(1, 9'h022, 16'h1234, 32'h0);
    rd(9'h020, "R5 mask low untouched");
    rd(9'h022, "R4 mask high written");
    rd(9'h01E, "R5 status high untouched by mask write");
    step(1, 9'h01E, 16'h0000, 32'h0);
    step(1, 9'h01C, 16'h0000, 32'h0);
    rd(9'h01C, "R2 status low cleared");
    cmd_busy = 1; wr_prot = 1;
    rd(9'h01E, "R3 busy live high");
    step(1, 9'h01E, 16'h0000, 32'h0);
    rd(9'h01E, "R3 busy survives clear");
    cmd_busy = 0;
    rd(9'h01E, "R3 busy drops at once");
    step(1, 9'h024, 16'h0000, 32'h0);
    rd(9'h024, "R9 unmapped reads zero");
    rd(9'h020, "R9 mask unchanged");
    step(1, 9'h020, 16'h0000, 32'h0);
    step(0, 9'h0, 0, 32'h0);
    chk("R6 irq from write protect", {31'h0, irq_n}, {31'h0, m_irqn});
    wr_prot = 0;
    step(0, 9'h0, 0, 32'h0);
    step(0, 9'h0, 0, 32'h0);
    chk("R6 irq released", {31'h0, irq_n}, 32'h1);

    for (int i = 0; i < 3000; i++) begin
      logic [8:0] a;
      logic [2:0] sel;
      card_sig = 1'($urandom); wr_prot = 1'($urandom); cmd_busy = 1'($urandom);
      sel = 3'($urandom);
      case (sel)
        0, 1: a = 9'h01C;
        2: a = 9'h01E;
        3: a = 9'h020;
        4: a = 9'h022;
        5: a = 9'($urandom);
        default: a = 9'h01C;
      endcase
      step(1'($urandom), a, 16'($urandom | $urandom),
           $urandom & $urandom & $urandom & $urandom);
      chk("R6 irq_n", {31'h0, irq_n}, {31'h0, m_irqn});
      sel = 3'($urandom_range(0, 4));
      case (sel)
        0: rd(9'h01C, "R1 R2 status low");
        1: rd(9'h01E, "R1 R2 status high");
        2: rd(9'h020, "R4 mask low");
        3: rd(9'h022, "R4 mask high");
        default: rd(9'h100, "R9 unmapped");
      endcase
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule